// File: doc/BRIEF.md
# Systolic Multiply-Accumulate Cell

This block is a single cell for an output-stationary systolic grid. On each enabled clock it registers the operand arriving from its west neighbour and passes it east. It registers the operand arriving from its north neighbour and passes it south. It also multiplies the two incoming operands as signed numbers and adds the product to a running sum held in a local accumulator register.

The accumulator register drives its own adder, so the cell keeps a running total of every product it has seen since reset. That total appears on a dedicated result port. A grid of these cells computes a matrix product: skewed rows enter from the west and skewed columns enter from the north, and each cell ends up holding one output element.

When the enable is low, the forwarding registers and the accumulator all keep their values. An active-low asynchronous reset clears all three. The accumulator does not saturate: it wraps modulo 2^ACC_W.

Top module: `sysmac_pe`

## Requirements
- R1: While rst_ni is low, and on the first edge after it is released with en_i low, west_o, south_o and sum_o are all zero.
- R2: After a rising clock edge with en_i high, west_o equals the value west_i had at that edge.
- R3: After a rising clock edge with en_i high, south_o equals the value north_i had at that edge.
- R4: After a rising clock edge with en_i high, sum_o equals its previous value plus the product of west_i and north_i at that edge.
- R5: On an edge with en_i low, west_o, south_o and sum_o keep their values whatever west_i and north_i carry.
- R6: Operands are two's-complement signed. For example, (-128)*(-128) adds +16384 and (-128)*127 adds -16256, and sum_o is read as a two's-complement ACC_W-bit value.
- R7: The sum wraps modulo 2^ACC_W without saturation. With the default widths, sixty-four additions of (-128)*(-128) starting from zero bring sum_o back to 0.
- R8: After a reset, an enabled sequence of three operand pairs leaves on sum_o their exact dot product. This holds even when every product is full-range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance forwarding registers and accumulate |
| west_i | input | DATA_W | Signed operand from west neighbour |
| north_i | input | DATA_W | Signed operand from north neighbour |
| west_o | output | DATA_W | Registered west operand, to east neighbour |
| south_o | output | DATA_W | Registered north operand, to south neighbour |
| sum_o | output | ACC_W | Running sum of products |

## Verification
The bench builds the cell with DATA_W=8 and ACC_W=20. These defaults bring the wrap boundary within reach: the most positive product, 16384, reaches 2^20 after exactly 64 enabled cycles. The same widths also make a full-range three-term dot product exact, and the operand extremes -128 and 127 exercise sign extension of the product into the wider accumulator.

// File: rtl/sysmac_pkg.sv
package sysmac_pkg;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_ACC_W  = 20;
endpackage

// File: rtl/sysmac_fwd_reg.sv
module sysmac_fwd_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/sysmac_mult.sv
module sysmac_mult #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  output logic signed [PROD_W-1:0] p_o
);
  always_comb p_o = $signed(a_i) * $signed(b_i);
endmodule

// File: rtl/sysmac_acc.sv
module sysmac_acc #(
  parameter int unsigned PROD_W = 16,
  parameter int unsigned ACC_W  = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]         acc_o
);
  logic signed [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0]        acc_d;

  always_comb begin
    prod_ext = prod_i;  // sign extension
    acc_d    = acc_o + prod_ext;  // feedback: register output into adder
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= acc_d;
  end
endmodule

// File: rtl/sysmac_pe.sv
module sysmac_pe #(
  parameter int unsigned DATA_W = sysmac_pkg::DEF_DATA_W,
  parameter int unsigned ACC_W  = sysmac_pkg::DEF_ACC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] west_i,
  input  logic [DATA_W-1:0] north_i,
  output logic [DATA_W-1:0] west_o,
  output logic [DATA_W-1:0] south_o,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;

  sysmac_fwd_reg #(.W(DATA_W)) u_fwd_east (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(west_i), .q_o(west_o)
  );

  sysmac_fwd_reg #(.W(DATA_W)) u_fwd_south (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .d_i(north_i), .q_o(south_o)
  );

  sysmac_mult #(.DATA_W(DATA_W)) u_mult (
    .a_i(west_i), .b_i(north_i), .p_o(prod)
  );

  sysmac_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .prod_i(prod), .acc_o(sum_o)
  );
endmodule

// File: rtl/sysmac_pe_chk.sv
module sysmac_pe_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DATA_W-1:0] west_i,
  input logic [DATA_W-1:0] north_i,
  input logic [DATA_W-1:0] west_o,
  input logic [DATA_W-1:0] south_o,
  input logic [ACC_W-1:0]  sum_o
);
  logic signed [ACC_W-1:0] exp_prod;
  logic [ACC_W-1:0]        exp_next;
  always_comb begin
    exp_prod = $signed(west_i) * $signed(north_i);
    exp_next = sum_o + exp_prod;
  end

  AST_RST_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (sum_o == '0 && west_o == '0 && south_o == '0)); // R1
  AST_FWD_EAST: assert property (@(posedge clk_i) disable iff (!rst_ni) en_i |=> west_o == $past(west_i)); // R2
  AST_FWD_SOUTH: assert property (@(posedge clk_i) disable iff (!rst_ni) en_i |=> south_o == $past(north_i)); // R3
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) en_i |=> sum_o == $past(exp_next)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !en_i |=> ($stable(sum_o) && $stable(west_o) && $stable(south_o))); // R5
endmodule

bind sysmac_pe sysmac_pe_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/sysmac_pe_tb_top.sv
`timescale 1ns/1ps
module sysmac_pe_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 20;
  localparam longint MASK = (longint'(1) << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic [DW-1:0] west_i = '0;
  logic [DW-1:0] north_i = '0;
  logic [DW-1:0] west_o, south_o;
  logic [AW-1:0] sum_o;

  int n_run = 0, n_fail = 0;
  longint m_sum = 0;
  logic [DW-1:0] m_east = '0, m_south = '0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  sysmac_pe #(.DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .west_i(west_i), .north_i(north_i),
    .west_o(west_o), .south_o(south_o), .sum_o(sum_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string rs, input string rw, input string rn);
    chk(rw, longint'(west_o), longint'(m_east));
    chk(rn, longint'(south_o), longint'(m_south));
    chk(rs, longint'(sum_o), m_sum & MASK);
  endtask

  // drive at negedge, model update at posedge, sample 1 ns after the edge
  task automatic step(input logic en, input logic [DW-1:0] a, input logic [DW-1:0] b, input string rs);
    @(negedge clk_i);
    en_i = en; west_i = a; north_i = b;
    @(posedge clk_i);
    if (en) begin
      m_sum   = m_sum + longint'($signed(a)) * longint'($signed(b));
      m_east  = a;
      m_south = b;
    end
    #1;
    if (en) cmp_all(rs, "R2", "R3");
    else    cmp_all("R5", "R5", "R5");
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b1; west_i = 8'h55; north_i = 8'hAA;
    #1;
    m_sum = 0; m_east = '0; m_south = '0;
    cmp_all("R1", "R1", "R1");
    @(negedge clk_i);
    rst_ni = 1'b1; en_i = 1'b0;
    @(posedge clk_i); #1;
    cmp_all("R1", "R1", "R1");
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    cmp_all("R1", "R1", "R1");
    do_reset();
    // R4: pseudo-random enabled stream
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(1'b1, lcg[15:8], lcg[31:24], "R4");
    end
    // R5: idle cycles with toggling operands
    for (int i = 0; i < 6; i++) step(1'b0, 8'(i * 37 + 1), 8'(255 - i * 19), "R5");
    // R4 with enable gaps
    for (int i = 0; i < 20; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      step(lcg[3], lcg[15:8], lcg[31:24], "R4");
    end
    // R6: operand extremes
    do_reset();
    step(1'b1, 8'h80, 8'h80, "R6");
    chk("R6", longint'(sum_o), 16384);
    step(1'b1, 8'h80, 8'h7F, "R6");
    chk("R6", longint'(sum_o), 128);
    step(1'b1, 8'hFF, 8'h01, "R6");
    chk("R6", longint'(sum_o), 127);
    step(1'b1, 8'h80, 8'h7F, "R6");
    chk("R6", longint'(sum_o), longint'((-16129) & MASK));
    // R8: full-range three-term dot product
    do_reset();
    step(1'b1, 8'h80, 8'h80, "R8");
    step(1'b1, 8'h80, 8'h80, "R8");
    step(1'b1, 8'h80, 8'h80, "R8");
    chk("R8", longint'(sum_o), 49152);
    do_reset();
    step(1'b1, 8'd3, 8'hFE, "R8");
    step(1'b1, 8'hF9, 8'd5, "R8");
    step(1'b1, 8'd11, 8'd4, "R8");
    chk("R8", longint'(sum_o), 3);
    // R7: wrap modulo 2^AW
    do_reset();
    for (int i = 0; i < 64; i++) step(1'b1, 8'h80, 8'h80, "R7");
    chk("R7", longint'(sum_o), 0);
    step(1'b1, 8'h80, 8'h80, "R7");
    chk("R7", longint'(sum_o), 16384);
    step(1'b1, 8'h7F, 8'h80, "R7");
    step(1'b1, 8'h7F, 8'h80, "R7");
    chk("R7", longint'(sum_o), longint'((-16128) & MASK));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule